// File: doc/BRIEF.md
# Per-Domain Access Permission Checker

This block sits beside a memory translation path and decides, for every read or write a bus master presents, whether it may proceed. Each translated page carries a 4-bit access-control index in bits 7:4 of its page entry; that index selects one of 16 permission domains. Each domain holds, for each of six masters, one "read unavailable" bit and one "write unavailable" bit. The translation walk itself is outside the block: the page entry arrives as an input alongside each access. The verdict is combinational, so the requester sees a grant or an error response in the same cycle.

When a master is refused, a small per-master state machine with the states FREE and HELD captures the access address and the page entry and raises that master's status bit. The transition FREE to HELD happens on a refusal. The transition HELD to FREE happens when software writes a one to the matching bit of the clear register. While a master is HELD, its captured values are frozen. Two further status bits record first-level and second-level walk faults that are reported by pulses from the walker. An interrupt line is high whenever a status bit and its enable bit are both set.

Register map (word offsets on an 8-bit configuration address):
- 0x00 to 0x1C: domain pair registers. Pair p holds domain 2p in bits 15:0 and domain 2p+1 in bits 31:16.
- 0x40: interrupt enable.
- 0x44: status, read only.
- 0x48: clear, write ones to clear; it reads as zero.
- 0x80 + 4m: captured address of master m.
- 0xA0 + 4m: captured page entry of master m.

Top module: `perm_checker`

## Requirements
- R1: The domain index of an access is page entry bits 7:4. Domain d lives in pair register d/2: an even d uses bits 15:0 and an odd d uses bits 31:16. Within a domain's 16 bits, bit 2m set refuses reads by master m, and bit 2m+1 set refuses writes by master m. A clear bit allows the access.
- R2: While acc_valid is high, exactly one of acc_grant and acc_error is high in the same cycle. Both outputs are low while acc_valid is low.
- R3: After reset, pair register 0 reads 0x00000AAA, so domain 0 allows reads and refuses writes for all six masters. All other pair registers, the enable register and the status register read zero, and irq is low.
- R4: A refused access by master m (m < 6) whose slot is FREE sets status bit m. From the next cycle, 0x80+4m reads the access address and 0xA0+4m reads the page entry.
- R5: While status bit m is set, later refusals of master m still get an error response but leave its captured address and entry unchanged. Other masters capture independently.
- R6: Writing the clear register clears exactly the status bits written as one; bits written as zero are unaffected. After its bit is cleared, a master captures its next refusal.
- R7: A pulse on walk_l1_fault sets status bit 16 and a pulse on walk_l2_fault sets status bit 17. Both bits stay set until cleared through the clear register.
- R8: The enable register stores only bits 5:0, 16 and 17. irq is high exactly when status AND enable is nonzero.
- R9: An access from master number 6 or 7 is always refused and changes no status bit.
- R10: Pair registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address, used for both read and write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr (combinational) |
| acc_valid | input | 1 | An access is presented |
| acc_master | input | 3 | Requesting master number |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 32 | Access address |
| acc_entry | input | 32 | Page entry that translated the access |
| acc_grant | output | 1 | Access allowed |
| acc_error | output | 1 | Access refused, error response |
| walk_l1_fault | input | 1 | Pulse: invalid first-level entry |
| walk_l2_fault | input | 1 | Pulse: invalid second-level entry |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a master that is already HELD and is refused again with a different address. That second refusal must not change the captured address or entry. It has to be distinguished from a fresh capture that follows a clear. The stimulus first latches master 1, then refuses master 1 again in a different domain while master 2 captures alongside it. It then clears bit 1 together with bit 16 and refuses master 1 once more with a new address, so the frozen value and the re-armed capture are both read back through the error registers.

// File: rtl/perm_pkg.sv
package perm_pkg;

    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_state_e;

    // Domain half with only the write-refuse bit set for the first n masters.
    function automatic logic [15:0] write_refuse_mask(input int n);
        logic [15:0] m;
        m = '0;
        for (int i = 0; i < n; i++) m[2*i+1] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/perm_table.sv
module perm_table #(
    parameter int N_DOMAINS = 16,
    parameter int HALF_W    = 16,
    parameter int MID_W     = 3,
    parameter logic [2*HALF_W-1:0] RESET0 = '0,
    localparam int N_PAIRS  = N_DOMAINS / 2,
    localparam int PAIR_W   = $clog2(N_PAIRS),
    localparam int ACI_W    = $clog2(N_DOMAINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [PAIR_W-1:0]   wr_pair,
    input  logic [2*HALF_W-1:0] wr_data,
    input  logic [PAIR_W-1:0]   rd_pair,
    output logic [2*HALF_W-1:0] rd_data,
    input  logic [ACI_W-1:0]    lk_aci,
    input  logic [MID_W-1:0]    lk_master,
    input  logic                lk_write,
    output logic                lk_refuse
);

    logic [2*HALF_W-1:0] pair_q [N_PAIRS];
    logic [2*HALF_W-1:0] sel_pair;
    logic [HALF_W-1:0]   sel_half;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < N_PAIRS; p++)
                pair_q[p] <= (p == 0) ? RESET0 : '0;
        end else if (wr_en) begin
            pair_q[wr_pair] <= wr_data;
        end
    end

    always_comb begin
        sel_pair  = pair_q[lk_aci[ACI_W-1:1]];
        sel_half  = lk_aci[0] ? sel_pair[2*HALF_W-1:HALF_W] : sel_pair[HALF_W-1:0];
        lk_refuse = sel_half[{lk_master, lk_write}];
    end

    assign rd_data = pair_q[rd_pair];

endmodule

// File: rtl/perm_fault_slot.sv
module perm_fault_slot
    import perm_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ENTRY_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic               release_i,
    input  logic [ADDR_W-1:0]  addr_in,
    input  logic [ENTRY_W-1:0] entry_in,
    output logic               held,
    output logic [ADDR_W-1:0]  err_addr,
    output logic [ENTRY_W-1:0] err_entry
);

    slot_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: if (capture)   state_d = SLOT_HELD;
            SLOT_HELD: if (release_i) state_d = SLOT_FREE;
            default:                  state_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_addr  <= '0;
            err_entry <= '0;
        end else if (state_q == SLOT_FREE && capture) begin
            err_addr  <= addr_in;
            err_entry <= entry_in;
        end
    end

    assign held = (state_q == SLOT_HELD);

endmodule

// File: rtl/perm_checker.sv
module perm_checker
    import perm_pkg::*;
#(
    parameter int N_MASTERS = 6,
    parameter int N_DOMAINS = 16,
    parameter int ADDR_W    = 32,
    parameter int ENTRY_W   = 32,
    parameter int MID_W     = 3,
    parameter int CFG_AW    = 8,
    parameter int ACI_LSB   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_en,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic               acc_valid,
    input  logic [MID_W-1:0]   acc_master,
    input  logic               acc_write,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [ENTRY_W-1:0] acc_entry,
    output logic               acc_grant,
    output logic               acc_error,
    input  logic               walk_l1_fault,
    input  logic               walk_l2_fault,
    output logic               irq
);

    localparam int ACI_W    = $clog2(N_DOMAINS);
    localparam int HALF_W   = 16;
    localparam int N_PAIRS  = N_DOMAINS / 2;
    localparam int PAIR_W   = $clog2(N_PAIRS);
    localparam int L1_BIT   = 16;
    localparam int L2_BIT   = 17;
    localparam int OFS_EN   = 'h40;
    localparam int OFS_STAT = 'h44;
    localparam int OFS_CLR  = 'h48;
    localparam int OFS_EA   = 'h80;
    localparam int OFS_ED   = 'hA0;
    localparam logic [31:0] EN_MASK = (32'd1 << L1_BIT) | (32'd1 << L2_BIT)
                                    | ((32'd1 << N_MASTERS) - 32'd1);
    localparam logic [31:0] RESET0  = {16'h0, write_refuse_mask(N_MASTERS)};

    logic                           pair_wr, master_ok, refuse, violate;
    logic [31:0]                    pair_rd, clr_bits, status_w, enable_q;
    logic                           l1_q, l2_q;
    logic [N_MASTERS-1:0]           slot_held;
    logic [N_MASTERS-1:0][ADDR_W-1:0]  err_addr_q;
    logic [N_MASTERS-1:0][ENTRY_W-1:0] err_entry_q;

    assign pair_wr  = cfg_wr_en && (int'(cfg_addr) < 4 * N_PAIRS);
    assign clr_bits = (cfg_wr_en && int'(cfg_addr) == OFS_CLR) ? cfg_wdata : '0;

    perm_table #(
        .N_DOMAINS (N_DOMAINS),
        .HALF_W    (HALF_W),
        .MID_W     (MID_W),
        .RESET0    (RESET0)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (pair_wr),
        .wr_pair   (cfg_addr[PAIR_W+1:2]),
        .wr_data   (cfg_wdata),
        .rd_pair   (cfg_addr[PAIR_W+1:2]),
        .rd_data   (pair_rd),
        .lk_aci    (acc_entry[ACI_LSB +: ACI_W]),
        .lk_master (acc_master),
        .lk_write  (acc_write),
        .lk_refuse (refuse)
    );

    assign master_ok = int'(acc_master) < N_MASTERS;
    assign violate   = !master_ok || refuse;
    assign acc_grant = acc_valid && !violate;
    assign acc_error = acc_valid && violate;

    for (genvar m = 0; m < N_MASTERS; m++) begin : g_slot
        perm_fault_slot #(
            .ADDR_W  (ADDR_W),
            .ENTRY_W (ENTRY_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .capture   (acc_valid && refuse && int'(acc_master) == m),
            .release_i (clr_bits[m]),
            .addr_in   (acc_addr),
            .entry_in  (acc_entry),
            .held      (slot_held[m]),
            .err_addr  (err_addr_q[m]),
            .err_entry (err_entry_q[m])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l1_q     <= 1'b0;
            l2_q     <= 1'b0;
            enable_q <= '0;
        end else begin
            l1_q <= walk_l1_fault || (l1_q && !clr_bits[L1_BIT]);
            l2_q <= walk_l2_fault || (l2_q && !clr_bits[L2_BIT]);
            if (cfg_wr_en && int'(cfg_addr) == OFS_EN)
                enable_q <= cfg_wdata & EN_MASK;
        end
    end

    always_comb begin
        status_w                 = '0;
        status_w[N_MASTERS-1:0]  = slot_held;
        status_w[L1_BIT]         = l1_q;
        status_w[L2_BIT]         = l2_q;
    end

    assign irq = |(status_w & enable_q);

    always_comb begin
        cfg_rdata = '0;
        if (int'(cfg_addr) < 4 * N_PAIRS) cfg_rdata = pair_rd;
        else if (int'(cfg_addr) == OFS_EN)   cfg_rdata = enable_q;
        else if (int'(cfg_addr) == OFS_STAT) cfg_rdata = status_w;
        for (int m = 0; m < N_MASTERS; m++) begin
            if (int'(cfg_addr) == OFS_EA + 4 * m) cfg_rdata = 32'(err_addr_q[m]);
            if (int'(cfg_addr) == OFS_ED + 4 * m) cfg_rdata = 32'(err_entry_q[m]);
        end
    end

endmodule

// File: rtl/perm_checker_sva.sv
module perm_checker_sva #(
    parameter int N_MASTERS = 6,
    parameter int ADDR_W    = 32,
    parameter int MID_W     = 3
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            acc_valid,
    input logic [MID_W-1:0]                acc_master,
    input logic [ADDR_W-1:0]               acc_addr,
    input logic                            acc_grant,
    input logic                            acc_error,
    input logic                            walk_l1_fault,
    input logic                            walk_l2_fault,
    input logic [N_MASTERS-1:0]            held,
    input logic [N_MASTERS-1:0][ADDR_W-1:0] eaddr,
    input logic [31:0]                     clr,
    input logic [31:0]                     status
);

    p_one_verdict_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> (acc_grant != acc_error));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !(acc_grant || acc_error));

    p_bad_master_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && int'(acc_master) >= N_MASTERS) |-> (acc_error && !acc_grant));

    p_walk_l1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        walk_l1_fault |=> status[16]);

    p_walk_l2_r7: assert property (@(posedge clk) disable iff (!rst_n)
        walk_l2_fault |=> status[17]);

    for (genvar m = 0; m < N_MASTERS; m++) begin : g_m
        p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid && acc_error && int'(acc_master) == m && !held[m])
            |=> (held[m] && eaddr[m] == $past(acc_addr)));

        p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (held[m] && !clr[m]) |=> (held[m] && $stable(eaddr[m])));

        p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (held[m] && clr[m]) |=> !held[m]);
    end

endmodule

bind perm_checker perm_checker_sva #(
    .N_MASTERS (N_MASTERS),
    .ADDR_W    (ADDR_W),
    .MID_W     (MID_W)
) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid     (acc_valid),
    .acc_master    (acc_master),
    .acc_addr      (acc_addr),
    .acc_grant     (acc_grant),
    .acc_error     (acc_error),
    .walk_l1_fault (walk_l1_fault),
    .walk_l2_fault (walk_l2_fault),
    .held          (slot_held),
    .eaddr         (err_addr_q),
    .clr           (clr_bits),
    .status        (status_w)
);

// File: tb/perm_checker_tb.sv
module perm_checker_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic [2:0]  acc_master = '0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [31:0] acc_entry = '0;
    logic        acc_grant, acc_error;
    logic        walk_l1_fault = 1'b0;
    logic        walk_l2_fault = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [1:0] exp_q [$];
    string      tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    perm_checker u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
        .acc_master(acc_master), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_entry(acc_entry), .acc_grant(acc_grant), .acc_error(acc_error),
        .walk_l1_fault(walk_l1_fault), .walk_l2_fault(walk_l2_fault), .irq(irq)
    );

    function automatic logic [31:0] mk_entry(input logic [19:0] page, input logic [3:0] dom);
        return {page, 4'h0, dom, 4'h2};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(tag, cfg_rdata, exp);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = d; cfg_wr_en = 1'b1;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    // Driver: presents one access and queues {grant,error} expected by the requirements.
    task automatic do_access(input string tag, input logic [2:0] m, input logic w,
                             input logic [31:0] a, input logic [31:0] e, input logic ok);
        @(negedge clk);
        acc_valid = 1'b1; acc_master = m; acc_write = w; acc_addr = a; acc_entry = e;
        exp_q.push_back({ok, !ok});
        tag_q.push_back(tag);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic pulse_l1();
        @(negedge clk); walk_l1_fault = 1'b1;
        @(negedge clk); walk_l1_fault = 1'b0;
    endtask

    task automatic pulse_l2();
        @(negedge clk); walk_l2_fault = 1'b1;
        @(negedge clk); walk_l2_fault = 1'b0;
    endtask

    // Monitor: pops expected verdicts and compares mid-cycle.
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (acc_valid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected access", 32'(1), 32'(0));
            end else begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, 32'({acc_grant, acc_error}), 32'(e));
            end
        end else if (rst_n && (acc_grant || acc_error)) begin
            check("R2 idle outputs", 32'({acc_grant, acc_error}), 32'(0));
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        rd_check("R3 pair0 reset", 8'h00, 32'h0000_0AAA);
        rd_check("R3 pair1 reset", 8'h04, 32'h0);
        rd_check("R3 status reset", 8'h44, 32'h0);
        rd_check("R3 enable reset", 8'h40, 32'h0);
        check("R3 irq reset", 32'(irq), 32'(0));

        // dom1 none, dom0 read-only; dom3 write-only, dom2 read-only; dom4/5 read-write
        wr(8'h00, 32'h0FFF_0AAA);
        wr(8'h04, 32'h0555_0AAA);
        wr(8'h08, 32'h0);
        rd_check("R10 pair0 readback", 8'h00, 32'h0FFF_0AAA);
        rd_check("R10 pair1 readback", 8'h04, 32'h0555_0AAA);

        do_access("R1 m0 read dom4",  3'd0, 1'b0, 32'h0000_1000, mk_entry(20'h00001, 4'd4), 1'b1);
        do_access("R1 m0 write dom4", 3'd0, 1'b1, 32'h0000_2000, mk_entry(20'h00002, 4'd4), 1'b1);
        do_access("R1 m1 read dom2",  3'd1, 1'b0, 32'h0000_3000, mk_entry(20'h00003, 4'd2), 1'b1);
        do_access("R1 m1 write dom2", 3'd1, 1'b1, 32'h1000_1000, mk_entry(20'h10001, 4'd2), 1'b0);
        rd_check("R4 status m1", 8'h44, 32'h2);
        rd_check("R4 m1 addr", 8'h84, 32'h1000_1000);
        rd_check("R4 m1 entry", 8'hA4, mk_entry(20'h10001, 4'd2));
        check("R8 irq masked", 32'(irq), 32'(0));

        do_access("R5 m1 write dom1 held", 3'd1, 1'b1, 32'h2000_0000, mk_entry(20'h20000, 4'd1), 1'b0);
        do_access("R1 m2 read dom3",       3'd2, 1'b0, 32'h3000_0000, mk_entry(20'h30000, 4'd3), 1'b0);
        rd_check("R5 status m1 m2", 8'h44, 32'h6);
        rd_check("R5 m1 addr frozen", 8'h84, 32'h1000_1000);
        rd_check("R5 m1 entry frozen", 8'hA4, mk_entry(20'h10001, 4'd2));
        rd_check("R5 m2 addr", 8'h88, 32'h3000_0000);
        rd_check("R5 m2 entry", 8'hA8, mk_entry(20'h30000, 4'd3));

        do_access("R1 m5 read dom0",  3'd5, 1'b0, 32'h5000_1000, mk_entry(20'h50001, 4'd0), 1'b1);
        do_access("R1 m5 write dom0", 3'd5, 1'b1, 32'h5000_0000, mk_entry(20'h50000, 4'd0), 1'b0);
        rd_check("R4 status m5", 8'h44, 32'h26);

        // dom9 (odd, upper half) refuses reads of master 1; dom8 allows all
        wr(8'h10, 32'h0004_0000);
        do_access("R1 m1 read dom9 upper", 3'd1, 1'b0, 32'h0900_0000, mk_entry(20'h09000, 4'd9), 1'b0);
        do_access("R1 m0 read dom9",       3'd0, 1'b0, 32'h0900_1000, mk_entry(20'h09001, 4'd9), 1'b1);
        do_access("R1 m1 read dom8 lower", 3'd1, 1'b0, 32'h0800_0000, mk_entry(20'h08000, 4'd8), 1'b1);
        rd_check("R5 status unchanged", 8'h44, 32'h26);

        wr(8'h40, 32'hFFFF_FFFF);
        rd_check("R8 enable mask", 8'h40, 32'h0003_003F);
        wr(8'h40, 32'h0000_0004);
        check("R8 irq on m2", 32'(irq), 32'(1));
        wr(8'h40, 32'h0001_0000);
        check("R8 irq off", 32'(irq), 32'(0));
        pulse_l1();
        rd_check("R7 status l1", 8'h44, 32'h0001_0026);
        check("R8 irq on l1", 32'(irq), 32'(1));

        wr(8'h48, 32'h0000_0000);
        rd_check("R6 clear zeros", 8'h44, 32'h0001_0026);
        wr(8'h48, 32'h0001_0002);
        rd_check("R6 status after clear", 8'h44, 32'h0000_0024);
        check("R6 irq after clear", 32'(irq), 32'(0));
        rd_check("R6 clear reads zero", 8'h48, 32'h0);
        do_access("R6 m1 write dom2 rearm", 3'd1, 1'b1, 32'h6000_0000, mk_entry(20'h60000, 4'd2), 1'b0);
        rd_check("R6 status rearmed", 8'h44, 32'h26);
        rd_check("R6 m1 new addr", 8'h84, 32'h6000_0000);

        pulse_l2();
        rd_check("R7 status l2", 8'h44, 32'h0002_0026);
        wr(8'h48, 32'hFFFF_FFFF);
        rd_check("R7 status cleared", 8'h44, 32'h0);

        do_access("R9 master 6", 3'd6, 1'b0, 32'h7000_0000, mk_entry(20'h70000, 4'd4), 1'b0);
        do_access("R9 master 7", 3'd7, 1'b1, 32'h7000_1000, mk_entry(20'h70001, 4'd4), 1'b0);
        rd_check("R9 status untouched", 8'h44, 32'h0);

        @(negedge clk);
        #(CLK_PERIOD/4);
        check("R2 idle grant/error", 32'({acc_grant, acc_error}), 32'(0));
        check("R2 queue drained", 32'(exp_q.size()), 32'(0));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule